// File: doc/BRIEF.md
# Single-to-Brain-Float Format Converter

This block converts numbers between 32-bit single-precision floating point and the 16-bit brain-float format. Both formats use a sign bit and an 8-bit exponent. Single precision has 23 fraction bits and the short format has 7. Each operand carries a direction bit. When the bit is 1 the operand is narrowed from 32 to 16 bits. When it is 0 the operand is widened from 16 to 32 bits.

Narrowing first sorts the operand by its exponent and fraction fields into zero or denormal, infinity, NaN or normal. Zeros and denormals become a signed zero. Infinities pass through. NaNs keep their upper half and are always made quiet. Normal values are rounded to nearest with ties to even. Widening is exact: the 16-bit value fills the upper half of the word and the lower half is zero.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream after one register stage. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on a clock edge where `out_valid` and `out_ready` are both high. When the consumer holds `out_ready` low while a result is waiting, the result stays in the output register unchanged, and `in_ready` stays low until the register can be refilled. In the cycle where the waiting result leaves, a new operand can be taken at the same time, so the stream runs at one result per cycle.

Top module: `fp_bf16_cvt`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0.
- R2: Widening (`in_narrow`=0): `out_data` = {`in_data[15:0]`, 16'h0000}. `in_data[31:16]` has no effect on the result.
- R3: Narrowing an operand whose exponent field `in_data[30:23]` is all zeros (a zero or a denormal) gives `out_data[15:0]` = {`in_data[31]`, 15'b0}.
- R4: Narrowing an infinity (exponent all ones, fraction `in_data[22:0]` zero) gives `out_data[15:0]` = `in_data[31:16]`.
- R5: Narrowing a NaN (exponent all ones, fraction nonzero) gives `out_data[15:0]` = `in_data[31:16]` | 16'h0040. This covers both the quiet case (bit 22 set) and the signalling case (bit 22 clear), so the result is always a quiet NaN.
- R6: Narrowing a normal operand gives `out_data[15:0]` = (`in_data` + 32'h7FFF + `in_data[16]`)[31:16]. This is round to nearest, with exact halfway cases going to the value whose result bit 0 is 0.
- R7: A normal operand near the largest finite magnitude may round up to the infinity code 16'h7F80 or 16'hFF80. The result is not clamped.
- R8: For every narrowed result, `out_data[31:16]` is 0.
- R9: An operand taken on one clock edge is presented with `out_valid`=1 after that edge. Results come out in the order the operands were taken.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` stay the same on the next edge.
- R11: `in_ready` is 1 whenever the output stage is empty (`out_valid`=0) or `out_ready`=1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operand is valid |
| in_ready | output | 1 | Converter can take an operand |
| in_narrow | input | 1 | 1: narrow 32 to 16 bits; 0: widen 16 to 32 bits |
| in_data | input | 32 | Operand (only the low 16 bits are used when widening) |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer can take the result |
| out_data | output | 32 | Result (a narrowed result sits in bits 15:0) |

## Verification
The directed patterns cover one example of each class:
- signed zeros and denormals with their sign bit set;
- both infinities;
- quiet and signalling NaNs;
- exact halfway cases with the kept bit 0 and with the kept bit 1;
- the largest finite values, which overflow to infinity.

Random operands are weighted toward these classes. This shows whether the classifier picks the right path and whether the rounding bias depends on the kept bit. Widening operands carry random junk in their upper half, so a result that uses the wrong half is caught. Random `out_ready` stalls are mixed in, so that lost or repeated results, results out of order, and data that changes while stalled are each caught.

// File: rtl/fpbf_pkg.sv
package fpbf_pkg;
  localparam int WIDE_W  = 32;
  localparam int SHORT_W = 16;
  localparam int EXP_W   = 8;
  localparam int WFRAC_W = WIDE_W - 1 - EXP_W;
  localparam int SFRAC_W = SHORT_W - 1 - EXP_W;
  localparam int DROP_W  = WIDE_W - SHORT_W;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_INF,
    CLS_SNAN,
    CLS_QNAN,
    CLS_NORM
  } fp_class_e;
endpackage

// File: rtl/fpbf_classify.sv
module fpbf_classify
  import fpbf_pkg::*;
#(
  parameter int W  = WIDE_W,
  parameter int EW = EXP_W
) (
  input  logic [W-1:0] op,
  output fp_class_e    cls
);
  localparam int FW = W - 1 - EW;

  logic [EW-1:0] ex;
  logic [FW-1:0] fr;

  assign ex = op[W-2 -: EW];
  assign fr = op[FW-1:0];

  always_comb begin
    if (ex == '0)
      cls = (fr == '0) ? CLS_ZERO : CLS_SUB;
    else if (ex == '1) begin
      if (fr == '0)       cls = CLS_INF;
      else if (fr[FW-1])  cls = CLS_QNAN;
      else                cls = CLS_SNAN;
    end else
      cls = CLS_NORM;
  end
endmodule

// File: rtl/fpbf_narrow.sv
module fpbf_narrow
  import fpbf_pkg::*;
#(
  parameter int W  = WIDE_W,
  parameter int SW = SHORT_W,
  parameter int EW = EXP_W
) (
  input  logic [W-1:0]  op,
  output logic [SW-1:0] res
);
  localparam int DW    = W - SW;
  localparam int SFW   = SW - 1 - EW;
  localparam logic [W-1:0] HALF_M1 = (W'(1) << (DW - 1)) - W'(1);
  localparam logic [SW-1:0] QUIET = SW'(1) << (SFW - 1);

  fp_class_e    cls;
  logic [W-1:0] bias;
  logic [W-1:0] sum;
  logic [SW-1:0] top;

  fpbf_classify #(.W(W), .EW(EW)) u_cls (
    .op  (op),
    .cls (cls)
  );

  assign top  = op[W-1 -: SW];
  assign bias = HALF_M1 + W'(op[DW]);
  assign sum  = op + bias;

  always_comb begin
    unique case (cls)
      CLS_ZERO, CLS_SUB: res = {op[W-1], {(SW-1){1'b0}}};
      CLS_INF:           res = top;
      CLS_SNAN, CLS_QNAN: res = top | QUIET;
      default:           res = sum[W-1 -: SW];
    endcase
  end
endmodule

// File: rtl/fpbf_widen.sv
module fpbf_widen #(
  parameter int W  = 32,
  parameter int SW = 16
) (
  input  logic [SW-1:0] op,
  output logic [W-1:0]  res
);
  assign res = {op, {(W-SW){1'b0}}};
endmodule

// File: rtl/fpbf_out_stage.sv
module fpbf_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         load;

  assign up_ready = dn_ready | ~vld_q;
  assign load     = up_valid & up_ready;

  always_ff @(posedge clk) begin
    if (rst)
      vld_q <= 1'b0;
    else if (up_ready)
      vld_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (load)
      dat_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;
endmodule

// File: rtl/fp_bf16_cvt.sv
module fp_bf16_cvt
  import fpbf_pkg::*;
#(
  parameter int W  = WIDE_W,
  parameter int SW = SHORT_W,
  parameter int EW = EXP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_narrow,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [SW-1:0] nar_res;
  logic [W-1:0]  wid_res;
  logic [W-1:0]  sel_res;

  fpbf_narrow #(.W(W), .SW(SW), .EW(EW)) u_nar (
    .op  (in_data),
    .res (nar_res)
  );

  fpbf_widen #(.W(W), .SW(SW)) u_wid (
    .op  (in_data[SW-1:0]),
    .res (wid_res)
  );

  assign sel_res = in_narrow ? {{(W-SW){1'b0}}, nar_res} : wid_res;

  fpbf_out_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (sel_res),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: rtl/fp_bf16_cvt_chk.sv
module fp_bf16_cvt_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_narrow,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  logic take;
  assign take = in_valid && in_ready;

  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_widen_R2: assert property (@(posedge clk) disable iff (rst)
    take && !in_narrow |=> out_data == {$past(in_data[15:0]), 16'h0000});

  assert_flush_R3: assert property (@(posedge clk) disable iff (rst)
    take && in_narrow && in_data[30:23] == 8'h00
      |=> out_data == {16'h0000, $past(in_data[31]), 15'h0000});

  assert_quiet_nan_R5: assert property (@(posedge clk) disable iff (rst)
    take && in_narrow && in_data[30:23] == 8'hFF && in_data[22:0] != 0
      |=> out_data[14:6] == 9'h1FF);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    take && in_narrow |=> out_data[31:16] == 16'h0000);

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_empty_ready_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind fp_bf16_cvt fp_bf16_cvt_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_narrow (in_narrow),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_fp_bf16_cvt.sv
`timescale 1ns/1ps
module tb_fp_bf16_cvt;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_narrow;
  logic [31:0] in_data;
  logic        out_valid, out_ready;
  logic [31:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  fp_bf16_cvt dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_narrow(in_narrow), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [31:0] model(input logic nar, input logic [31:0] x);
    logic [31:0] s;
    if (!nar) return {x[15:0], 16'h0000};
    if (x[30:23] == 8'h00) return {16'h0, x[31], 15'h0};
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] == 0) return {16'h0, x[31:16]};
      return {16'h0, x[31:16] | 16'h0040};
    end
    s = x + 32'h0000_7FFF + {31'h0, x[16]};
    return {16'h0, s[31:16]};
  endfunction

  function automatic string req_of(input logic nar, input logic [31:0] x);
    if (!nar) return "R2";
    if (x[30:23] == 8'h00) return "R3";
    if (x[30:23] == 8'hFF) return (x[22:0] == 0) ? "R4" : "R5";
    if (x[30:23] == 8'hFE) return "R7";
    return "R6";
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  logic        stall_prev = 0;
  logic [31:0] stall_data;
  logic        took_prev = 0;

  // One cycle: inputs are driven at the falling edge, handshakes evaluated just after.
  task automatic cycle(input logic iv, input logic nar, input logic [31:0] d,
                       input logic ordy, output logic taken);
    @(negedge clk);
    in_valid = iv; in_narrow = nar; in_data = d; out_ready = ordy;
    #0.5;
    if (took_prev) check("R9", {31'h0, out_valid}, 32'h1);
    if (stall_prev) begin
      check("R10", {31'h0, out_valid}, 32'h1);
      check("R10", out_data, stall_data);
    end
    check("R11", {31'h0, in_ready}, {31'h0, out_ready | ~out_valid});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R9", 32'hDEAD, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_data, e);
        if (t != "R2") check("R8", {16'h0, out_data[31:16]}, 32'h0);
      end
    end
    stall_prev = out_valid && !out_ready;
    stall_data = out_data;
    taken = iv && in_ready;
    took_prev = taken;
    if (taken) begin
      exp_q.push_back(model(nar, d));
      tag_q.push_back(req_of(nar, d));
    end
  endtask

  task automatic send(input logic nar, input logic [31:0] d, input logic ordy_rand);
    logic tk;
    tk = 0;
    while (!tk) cycle(1'b1, nar, d, ordy_rand ? 1'($urandom % 4 != 0) : 1'b1, tk);
  endtask

  function automatic logic [31:0] rnd_op(input int k);
    logic [31:0] r;
    r = $urandom;
    case (k)
      0: r[30:23] = 8'h00;
      1: begin r[30:23] = 8'hFF; r[22:0] = 0; end
      2: r[30:23] = 8'hFF;
      3: r[15:0] = 16'h8000;
      4: begin r[30:16] = 15'h7F7F; end
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic tk;
    void'($urandom(32'd4242));
    rst = 1; in_valid = 0; in_narrow = 0; in_data = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    check("R1", {31'h0, out_valid}, 32'h0);
    @(negedge clk); rst = 0;
    #0.5 check("R1", {31'h0, out_valid}, 32'h0);

    // directed corners
    send(1'b0, 32'hDEAD_1234, 0);   // R2: upper half ignored
    send(1'b0, 32'h0000_3F80, 0);
    send(1'b1, 32'h0000_0000, 0);   // R3
    send(1'b1, 32'h8000_0001, 0);   // R3 negative denormal
    send(1'b1, 32'h7F80_0000, 0);   // R4
    send(1'b1, 32'hFF80_0000, 0);   // R4
    send(1'b1, 32'h7F80_0001, 0);   // R5 signalling
    send(1'b1, 32'hFFC0_1234, 0);   // R5 quiet
    send(1'b1, 32'h3F80_8000, 0);   // R6 tie, kept even
    send(1'b1, 32'h3F81_8000, 0);   // R6 tie, kept odd
    send(1'b1, 32'h3F80_8001, 0);   // R6 above half
    send(1'b1, 32'h7F7F_FFFF, 0);   // R7 -> 7F80
    send(1'b1, 32'hFF7F_FFFF, 0);   // R7 -> FF80
    // stall: hold output for several cycles (R10)
    cycle(1'b1, 1'b1, 32'h4049_0FDB, 1'b0, tk);
    repeat (3) cycle(1'b1, 1'b1, 32'h4049_0FDB, 1'b0, tk);
    // random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic nar;
      nar = 1'($urandom % 4 != 0);
      if ($urandom % 5 == 0) cycle(1'b0, 1'b0, 32'h0, 1'($urandom % 2), tk);
      else send(nar, rnd_op(int'($urandom % 8)), 1);
    end
    while (exp_q.size() != 0) cycle(1'b0, 1'b0, 32'h0, 1'b1, tk);
    cycle(1'b0, 1'b0, 32'h0, 1'b1, tk);
    check("R9", {31'h0, out_valid}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule